// File: doc/BRIEF.md
# Discrete Double-Barrier Knock-Out Payoff Evaluator

This block scores simulated price paths for a double-barrier knock-out call. A path generator sends one price sample per clock, tagged with a path number and a step index. Samples from many paths may be interleaved in any order from cycle to cycle. For each path the block keeps a knocked-out bit. A sample sets that bit when its price lies on or beyond either barrier. Before the comparison, each barrier is moved inward by a programmable correction. This makes up for barrier crossings that happen between two samples and are never seen.

When the step index equals the programmed maturity step, the block outputs the call payoff for that path: the price above the strike, or zero if the path was knocked out at any sampled step. Step zero starts a fresh path. Software loads the barriers, the correction, the strike and the maturity step while no samples are flowing. Prices are unsigned fixed-point numbers. The block does not interpret the binary point, as long as all values use the same scaling.

Top module: `barrier_ko_eval`

## Requirements
- R1: While reset is held, and after its release, out_valid, out_path and out_payoff are zero and every path's knocked-out bit is clear.
- R2: A configuration write takes effect when cfg_we is high and in_valid is low. cfg_sel codes are: 0 lower barrier, 1 upper barrier, 2 correction, 3 strike, 4 maturity step (low STEP_W bits of cfg_data). A write made while in_valid is high is ignored.
- R3: The effective lower barrier is lower plus correction, saturating at the all-ones value. The effective upper barrier is upper minus correction, saturating at zero.
- R4: A sample hits when its price is less than or equal to the effective lower barrier, or greater than or equal to the effective upper barrier. Equality counts as a hit.
- R5: Once a path has hit at any sample, its payoff at maturity is zero, whatever its final price.
- R6: A sample with step index 0 clears that path's knocked-out bit before its own hit test, so a hit at step 0 still knocks the path out.
- R7: For a path that was never knocked out, the payoff is price minus strike when the price exceeds the strike, and zero otherwise (including price equal to strike).
- R8: out_valid is raised only for a sample whose step index equals the maturity step. Earlier steps only update the knocked-out bit.
- R9: The result of a sample appears on the outputs after the third rising edge, counting the edge that samples it. out_path repeats that sample's path number.
- R10: Paths are tracked independently. A sample of a path in the cycle right after a hit of the same path sees that hit.
- R11: While out_valid is low, out_path and out_payoff are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_data | input | PRICE_W | Configuration write value |
| in_valid | input | 1 | Sample present |
| in_path | input | PATH_W | Path number of the sample |
| in_step | input | STEP_W | Step index of the sample |
| in_price | input | PRICE_W | Sampled asset price |
| out_valid | output | 1 | Maturity result present |
| out_path | output | PATH_W | Path number of the result |
| out_payoff | output | PRICE_W | Call payoff for the path |

## Verification
A sample that is clocked in at one edge produces its payoff two edges later, so the result is visible in the third cycle after the sample. The bench drives inputs on falling edges. In the vector walk it checks the result for vector j-3 on the same falling edge where it drives vector j, so each result is sampled in the one cycle when it is due. Directed tests send a path and then idle for exactly three falling edges before checking. In the checker, a saturating count of cycles since reset guards every three-cycle look-back.

// File: rtl/bko_pkg.sv
package bko_pkg;

   typedef enum logic [2:0] {
      CFG_LOWER  = 3'd0,
      CFG_UPPER  = 3'd1,
      CFG_CORR   = 3'd2,
      CFG_STRIKE = 3'd3,
      CFG_MATURE = 3'd4
   } cfg_sel_e;

   localparam int unsigned LATENCY = 3;

endpackage

// File: rtl/bko_cfg_regs.sv
module bko_cfg_regs
   import bko_pkg::*;
#(
   parameter int unsigned PRICE_W = 16,
   parameter int unsigned STEP_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_sel,
   input  logic [PRICE_W-1:0] wr_data,
   output logic [PRICE_W-1:0] lo_eff,
   output logic [PRICE_W-1:0] hi_eff,
   output logic [PRICE_W-1:0] strike,
   output logic [STEP_W-1:0]  mat_step
);

   localparam logic [PRICE_W-1:0] ALL_ONES = {PRICE_W{1'b1}};

   logic [PRICE_W-1:0] lower_q, upper_q, corr_q, strike_q;
   logic [STEP_W-1:0]  mat_q;
   logic [PRICE_W:0]   lo_sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lower_q  <= '0;
         upper_q  <= ALL_ONES;
         corr_q   <= '0;
         strike_q <= '0;
         mat_q    <= '1;
      end else if (wr_en) begin
         case (cfg_sel_e'(wr_sel))
            CFG_LOWER:  lower_q  <= wr_data;
            CFG_UPPER:  upper_q  <= wr_data;
            CFG_CORR:   corr_q   <= wr_data;
            CFG_STRIKE: strike_q <= wr_data;
            CFG_MATURE: mat_q    <= wr_data[STEP_W-1:0];
            default: ;
         endcase
      end
   end

   // inward shift with saturation on both sides
   always_comb begin
      lo_sum = {1'b0, lower_q} + {1'b0, corr_q};
      lo_eff = lo_sum[PRICE_W] ? ALL_ONES : lo_sum[PRICE_W-1:0];
      hi_eff = (corr_q > upper_q) ? '0 : (upper_q - corr_q);
   end

   assign strike   = strike_q;
   assign mat_step = mat_q;

endmodule

// File: rtl/bko_flag_store.sv
module bko_flag_store #(
   parameter int unsigned PATH_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PATH_W-1:0] rd_addr,
   output logic              rd_flag,
   input  logic              wr_en,
   input  logic [PATH_W-1:0] wr_addr,
   input  logic              wr_flag
);

   localparam int unsigned DEPTH = 1 << PATH_W;

   logic [DEPTH-1:0] flags;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n)
               flags[g] <= 1'b0;
            else if (wr_en && (wr_addr == PATH_W'(g)))
               flags[g] <= wr_flag;
         end
      end
   endgenerate

   assign rd_flag = flags[rd_addr];

endmodule

// File: rtl/bko_payoff.sv
module bko_payoff #(
   parameter int unsigned PRICE_W = 16
) (
   input  logic [PRICE_W-1:0] price,
   input  logic [PRICE_W-1:0] strike,
   input  logic               knocked,
   output logic [PRICE_W-1:0] payoff
);

   logic in_money;

   always_comb begin
      in_money = price > strike;
      payoff   = (in_money && !knocked) ? (price - strike) : '0;
   end

endmodule

// File: rtl/barrier_ko_eval.sv
module barrier_ko_eval
   import bko_pkg::*;
#(
   parameter int unsigned PRICE_W = 16,
   parameter int unsigned PATH_W  = 4,
   parameter int unsigned STEP_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [PRICE_W-1:0] cfg_data,
   input  logic               in_valid,
   input  logic [PATH_W-1:0]  in_path,
   input  logic [STEP_W-1:0]  in_step,
   input  logic [PRICE_W-1:0] in_price,
   output logic               out_valid,
   output logic [PATH_W-1:0]  out_path,
   output logic [PRICE_W-1:0] out_payoff
);

   generate
      if (PRICE_W < 4 || PRICE_W > 64) begin : g_bad_price_w
         $error("barrier_ko_eval: PRICE_W out of range");
      end
      if (PATH_W < 1 || PATH_W > 10) begin : g_bad_path_w
         $error("barrier_ko_eval: PATH_W out of range");
      end
      if (STEP_W < 1 || STEP_W > PRICE_W) begin : g_bad_step_w
         $error("barrier_ko_eval: STEP_W out of range");
      end
   endgenerate

   logic [PRICE_W-1:0] lo_eff, hi_eff, strike_q;
   logic [STEP_W-1:0]  mat_step;
   logic               cfg_take;

   assign cfg_take = cfg_we && !in_valid;

   bko_cfg_regs #(.PRICE_W(PRICE_W), .STEP_W(STEP_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_take),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_data),
      .lo_eff   (lo_eff),
      .hi_eff   (hi_eff),
      .strike   (strike_q),
      .mat_step (mat_step)
   );

   // stage 1: capture sample and barrier test
   logic               s1_valid, s1_new, s1_mat, s1_hit;
   logic [PATH_W-1:0]  s1_path;
   logic [PRICE_W-1:0] s1_price;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_new   <= 1'b0;
         s1_mat   <= 1'b0;
         s1_hit   <= 1'b0;
         s1_path  <= '0;
         s1_price <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_path  <= in_path;
            s1_price <= in_price;
            s1_new   <= (in_step == '0);
            s1_mat   <= (in_step == mat_step);
            s1_hit   <= (in_price <= lo_eff) || (in_price >= hi_eff);
         end
      end
   end

   // stage 2: merge with the sticky per-path bit
   logic rd_flag, ko_now;

   assign ko_now = s1_hit || (!s1_new && rd_flag);

   bko_flag_store #(.PATH_W(PATH_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (s1_path),
      .rd_flag (rd_flag),
      .wr_en   (s1_valid),
      .wr_addr (s1_path),
      .wr_flag (ko_now)
   );

   logic               s2_valid, s2_ko;
   logic [PATH_W-1:0]  s2_path;
   logic [PRICE_W-1:0] s2_price;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_ko    <= 1'b0;
         s2_path  <= '0;
         s2_price <= '0;
      end else begin
         s2_valid <= s1_valid && s1_mat;
         s2_ko    <= ko_now;
         s2_path  <= s1_path;
         s2_price <= s1_price;
      end
   end

   // stage 3: payoff and output register
   logic [PRICE_W-1:0] pay_c;

   bko_payoff #(.PRICE_W(PRICE_W)) u_pay (
      .price   (s2_price),
      .strike  (strike_q),
      .knocked (s2_ko),
      .payoff  (pay_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_path   <= '0;
         out_payoff <= '0;
      end else begin
         out_valid  <= s2_valid;
         out_path   <= s2_valid ? s2_path : '0;
         out_payoff <= s2_valid ? pay_c : '0;
      end
   end

endmodule

// File: rtl/bko_eval_chk.sv
module bko_eval_chk #(
   parameter int unsigned PRICE_W = 16,
   parameter int unsigned PATH_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic               in_valid,
   input logic [PATH_W-1:0]  in_path,
   input logic [PRICE_W-1:0] in_price,
   input logic [PRICE_W-1:0] lo_eff,
   input logic [PRICE_W-1:0] hi_eff,
   input logic [PRICE_W-1:0] strike_q,
   input logic               out_valid,
   input logic [PATH_W-1:0]  out_path,
   input logic [PRICE_W-1:0] out_payoff
);

   logic [1:0] since_rst;
   logic       warm;

   always_ff @(posedge clk) begin
      if (!rst_n)
         since_rst <= '0;
      else if (since_rst != 2'd3)
         since_rst <= since_rst + 2'd1;
   end

   assign warm = (since_rst == 2'd3);

   // R11
   idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_payoff == '0 && out_path == '0));

   // R9
   result_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid) |-> ($past(in_valid, 3) && out_path == $past(in_path, 3)));

   // R7
   payoff_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && out_payoff != '0) |->
         (out_payoff == $past(in_price, 3) - $past(strike_q)));

   // R4
   paid_path_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && out_payoff != '0) |->
         ($past(in_price, 3) > $past(lo_eff, 3) && $past(in_price, 3) < $past(hi_eff, 3)));

   // R2
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && in_valid) |=> $stable(strike_q));

endmodule

bind barrier_ko_eval bko_eval_chk #(.PRICE_W(PRICE_W), .PATH_W(PATH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .in_valid   (in_valid),
   .in_path    (in_path),
   .in_price   (in_price),
   .lo_eff     (lo_eff),
   .hi_eff     (hi_eff),
   .strike_q   (strike_q),
   .out_valid  (out_valid),
   .out_path   (out_path),
   .out_payoff (out_payoff)
);

// File: tb/barrier_ko_eval_tb.sv
module barrier_ko_eval_tb;

   localparam int CLK_PERIOD = 10;
   localparam int PW = 16;
   localparam int IW = 4;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [2:0]    cfg_sel;
   logic [PW-1:0] cfg_data;
   logic          in_valid;
   logic [IW-1:0] in_path;
   logic [SW-1:0] in_step;
   logic [PW-1:0] in_price;
   logic          out_valid;
   logic [IW-1:0] out_path;
   logic [PW-1:0] out_payoff;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   barrier_ko_eval #(.PRICE_W(PW), .PATH_W(IW), .STEP_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .in_valid(in_valid), .in_path(in_path), .in_step(in_step), .in_price(in_price),
      .out_valid(out_valid), .out_path(out_path), .out_payoff(out_payoff)
   );

   typedef struct packed {
      logic [3:0]  path;
      logic [3:0]  step;
      logic [15:0] price;
      logic        ev;
      logic [15:0] ep;
   } vec_t;

   // lower 90, upper 110, correction 2 -> effective 92 / 108; strike 100; maturity step 3
   localparam int NV = 32;
   localparam vec_t VEC [NV] = '{
      '{4'd0, 4'd0, 16'd100, 1'b0, 16'd0},
      '{4'd1, 4'd0, 16'd100, 1'b0, 16'd0},
      '{4'd2, 4'd0, 16'd100, 1'b0, 16'd0},
      '{4'd0, 4'd1, 16'd105, 1'b0, 16'd0},
      '{4'd1, 4'd1, 16'd108, 1'b0, 16'd0},
      '{4'd2, 4'd1, 16'd93,  1'b0, 16'd0},
      '{4'd0, 4'd2, 16'd107, 1'b0, 16'd0},
      '{4'd1, 4'd2, 16'd100, 1'b0, 16'd0},
      '{4'd2, 4'd2, 16'd92,  1'b0, 16'd0},
      '{4'd0, 4'd3, 16'd106, 1'b1, 16'd6},
      '{4'd1, 4'd3, 16'd105, 1'b1, 16'd0},
      '{4'd2, 4'd3, 16'd104, 1'b1, 16'd0},
      '{4'd3, 4'd0, 16'd100, 1'b0, 16'd0},
      '{4'd3, 4'd1, 16'd99,  1'b0, 16'd0},
      '{4'd3, 4'd2, 16'd100, 1'b0, 16'd0},
      '{4'd3, 4'd3, 16'd95,  1'b1, 16'd0},
      '{4'd1, 4'd0, 16'd100, 1'b0, 16'd0},
      '{4'd1, 4'd1, 16'd101, 1'b0, 16'd0},
      '{4'd1, 4'd2, 16'd102, 1'b0, 16'd0},
      '{4'd1, 4'd3, 16'd107, 1'b1, 16'd7},
      '{4'd4, 4'd0, 16'd100, 1'b0, 16'd0},
      '{4'd4, 4'd1, 16'd91,  1'b0, 16'd0},
      '{4'd4, 4'd2, 16'd100, 1'b0, 16'd0},
      '{4'd4, 4'd3, 16'd105, 1'b1, 16'd0},
      '{4'd5, 4'd0, 16'd109, 1'b0, 16'd0},
      '{4'd5, 4'd1, 16'd101, 1'b0, 16'd0},
      '{4'd5, 4'd2, 16'd101, 1'b0, 16'd0},
      '{4'd5, 4'd3, 16'd101, 1'b1, 16'd0},
      '{4'd6, 4'd0, 16'd100, 1'b0, 16'd0},
      '{4'd6, 4'd1, 16'd100, 1'b0, 16'd0},
      '{4'd6, 4'd2, 16'd100, 1'b0, 16'd0},
      '{4'd6, 4'd3, 16'd100, 1'b1, 16'd0}
   };

   task automatic check(input string req, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_out(input string req, input logic ev, input logic [IW-1:0] ep_path,
                            input logic [PW-1:0] ep);
      check({req, " valid"}, out_valid, ev);
      check({req, " path"}, out_path, ev ? ep_path : '0);
      check({req, " payoff"}, out_payoff, ev ? ep : '0);
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [PW-1:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic [IW-1:0] p, input logic [SW-1:0] s, input logic [PW-1:0] pr);
      @(negedge clk);
      in_valid = 1'b1; in_path = p; in_step = s; in_price = pr;
   endtask

   // after the last send: result visible at the third falling edge
   task automatic settle;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=1 expected=0");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0;
      in_valid = 1'b0; in_path = '0; in_step = '0; in_price = '0;
      repeat (3) @(negedge clk);
      // R1 outputs during reset
      check_out("R1 in reset", 1'b0, '0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 after reset", 1'b0, '0, '0);

      // R2 configuration through codes 0..4
      cfg(3'd0, 16'd90);
      cfg(3'd1, 16'd110);
      cfg(3'd2, 16'd2);
      cfg(3'd3, 16'd100);
      cfg(3'd4, 16'd3);

      // vector walk: R3 R4 R5 R6 R7 R8 R9 R10 R11
      for (int j = 0; j < NV + 3; j++) begin
         @(negedge clk);
         if (j >= 3)
            check_out($sformatf("R4/R5/R6/R7/R8/R9/R10 vec%0d", j - 3),
                      VEC[j-3].ev, VEC[j-3].path, VEC[j-3].ep);
         if (j < NV) begin
            in_valid = 1'b1; in_path = VEC[j].path; in_step = VEC[j].step; in_price = VEC[j].price;
         end else begin
            in_valid = 1'b0;
         end
      end

      // R2 write of strike 50 while a sample is present is ignored
      @(negedge clk);
      in_valid = 1'b1; in_path = 4'd7; in_step = 4'd0; in_price = 16'd100;
      cfg_we = 1'b1; cfg_sel = 3'd3; cfg_data = 16'd50;
      @(negedge clk);
      cfg_we = 1'b0;
      in_step = 4'd1; in_price = 16'd101;
      send(4'd7, 4'd2, 16'd102);
      send(4'd7, 4'd3, 16'd105);
      settle();
      check_out("R2 busy write ignored", 1'b1, 4'd7, 16'd5);

      // R3 zero correction: 91 no longer hits the shifted barrier
      cfg(3'd2, 16'd0);
      send(4'd8, 4'd0, 16'd100);
      send(4'd8, 4'd1, 16'd91);
      send(4'd8, 4'd2, 16'd109);
      send(4'd8, 4'd3, 16'd104);
      settle();
      check_out("R3 no correction", 1'b1, 4'd8, 16'd4);

      // R4 inclusive at uncorrected upper barrier
      send(4'd9, 4'd0, 16'd110);
      send(4'd9, 4'd3, 16'd104);
      settle();
      check_out("R4 equal upper", 1'b1, 4'd9, 16'd0);

      // R3 saturation: huge correction knocks out every path
      cfg(3'd2, 16'hFFFF);
      send(4'd10, 4'd0, 16'd100);
      send(4'd10, 4'd3, 16'd105);
      settle();
      check_out("R3 saturated correction", 1'b1, 4'd10, 16'd0);
      cfg(3'd2, 16'd2);

      // R8 maturity step moved to 1; step 3 now gives no result
      cfg(3'd4, 16'd1);
      send(4'd11, 4'd0, 16'd100);
      send(4'd11, 4'd1, 16'd103);
      settle();
      check_out("R8 maturity at 1", 1'b1, 4'd11, 16'd3);
      send(4'd11, 4'd3, 16'd103);
      settle();
      check_out("R8 non-maturity step silent", 1'b0, '0, '0);
      cfg(3'd4, 16'd3);

      // R1 reset clears knocked-out bits: path 12 hits, reset, then resumes at step 1
      send(4'd12, 4'd0, 16'd100);
      send(4'd12, 4'd1, 16'd50);
      settle();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R1 reset mid-run", 1'b0, '0, '0);
      rst_n = 1'b1;
      cfg(3'd0, 16'd90);
      cfg(3'd1, 16'd110);
      cfg(3'd2, 16'd2);
      cfg(3'd3, 16'd100);
      cfg(3'd4, 16'd3);
      send(4'd12, 4'd3, 16'd102);
      settle();
      check_out("R1 flag cleared by reset", 1'b1, 4'd12, 16'd2);

      finish_run();
   end

endmodule